// File: doc/BRIEF.md
# Three-Request Handshake Pipeline Buffer

This block is a first-in first-out buffer for flits travelling over a four-phase handshake link. The link has three separate request wires, one for each flit kind: header, intermediate and end. It also has one data word and one acknowledge. The buffer is a straight chain of identical stages. Each stage holds one completion element per request wire. An element is set when its upstream request is high and the downstream acknowledge is low. It is cleared when its upstream request is low and the downstream acknowledge is high. Otherwise it keeps its value. A stage acknowledges upstream with the OR of its three elements, and it presents those elements downstream as its own request wires. Its data register is open only while all three elements are clear and the downstream acknowledge is low. Once closed, it stays closed through the whole handshake, including return-to-zero.

The controller is the fully coupled kind. A stage takes no new flit until the handshake on its output has returned completely to zero. Because of this, a stalled chain holds a flit in at most every second stage. The flit kind is carried on its own request wire and never inside the data. This lets a downstream router tell packet boundaries apart with no decoding. The whole block is modelled synchronously: every completion element and data register updates on the rising clock edge.

Top module: `hs3_fifo`

## Requirements
- R1: After reset, all completion elements are clear, so `out_req` is 0 and `in_ack` is 0.
- R2: The request wire encoding is: bit 0 is header, bit 1 is intermediate and bit 2 is end. At most one bit is high at a time. Every flit leaves the chain on the same request bit it entered on, with the same data word and in the order of acceptance, so header/intermediate/end packets stay intact.
- R3: With the chain empty and `out_ack` low, a flit whose request is first sampled high at clock edge k appears on `out_req`/`out_data` after edge k+DEPTH-1, and not before.
- R4: When the first stage is empty and its downstream acknowledge is low, `in_ack` rises on the first edge at which `in_req` is sampled non-zero. It stays high while `in_req` stays non-zero, and it falls only after `in_req` has returned to zero.
- R5: While `out_req` is non-zero and `out_ack` is low, `out_req` and `out_data` hold their values.
- R6: After any cycle in which `out_ack` is high, `out_data` is unchanged on the next cycle, so output data stays valid through return-to-zero.
- R7: After the output request has fallen, the last stage presents no new flit while `out_ack` stays high. Once `out_ack` falls, a flit waiting in the stage before it appears on the next edge.
- R8: With `out_ack` held low, the chain accepts exactly (DEPTH+1)/2 flits (integer division) before `in_ack` stops completing handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 3 | Upstream request wires: bit 0 header, bit 1 intermediate, bit 2 end |
| in_data | input | WIDTH | Upstream flit data |
| in_ack | output | 1 | Acknowledge to upstream |
| out_req | output | 3 | Downstream request wires, same encoding as in_req |
| out_data | output | WIDTH | Downstream flit data |
| out_ack | input | 1 | Acknowledge from downstream |

## Verification
Two things can fall in the same cycle: a stage releases its flit, because its upstream request has dropped while its downstream acknowledge rises, and the stage behind it offers the next flit into the freed slot. The bench provokes this overlap with a sink that has no delay and a source that has no gap. It also mixes in random one- to three-cycle delays on both sides, so that release and refill line up in every combination. Every cycle is judged against a behavioural token model, and each delivered flit is checked against a queue of accepted flits for kind, data and order.

// File: rtl/hs3_pkg.sv
package hs3_pkg;
    localparam int KINDS     = 3;
    localparam int KIND_HEAD = 0;
    localparam int KIND_MID  = 1;
    localparam int KIND_TAIL = 2;

    typedef logic [KINDS-1:0] kind_vec_t;
endpackage

// File: rtl/hs3_celem_bank.sv
// One completion element per request wire of a stage.
module hs3_celem_bank
    import hs3_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  kind_vec_t req_up,
    input  logic      ack_dn,
    output kind_vec_t held
);
    typedef struct packed {
        kind_vec_t c;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < KINDS; k++) begin
            if (req_up[k] && !ack_dn) begin
                st_d.c[k] = 1'b1;
            end else if (!req_up[k] && ack_dn) begin
                st_d.c[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.c;
endmodule

// File: rtl/hs3_hold_latch.sv
// Data holding register: follows its input while open, keeps its value while closed.
module hs3_hold_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open,
    input  logic [WIDTH-1:0] d_up,
    output logic [WIDTH-1:0] d_out
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (open) begin
            st_d.data = d_up;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign d_out = st_q.data;
endmodule

// File: rtl/hs3_stage.sv
// One fully coupled stage: completion bank plus holding register.
module hs3_stage
    import hs3_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  kind_vec_t        req_up,
    input  logic [WIDTH-1:0] d_up,
    output logic             ack_up,
    output kind_vec_t        req_dn,
    output logic [WIDTH-1:0] d_dn,
    input  logic             ack_dn
);
    kind_vec_t held;
    logic      busy;
    logic      open;

    hs3_celem_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_up (req_up),
        .ack_dn (ack_dn),
        .held   (held)
    );

    // Closed while any element is set or the downstream handshake is still active.
    assign busy = |held;
    assign open = !(busy || ack_dn);

    hs3_hold_latch #(.WIDTH(WIDTH)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .open  (open),
        .d_up  (d_up),
        .d_out (d_dn)
    );

    assign ack_up = busy;
    assign req_dn = held;
endmodule

// File: rtl/hs3_fifo.sv
module hs3_fifo
    import hs3_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KINDS-1:0] in_req,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ack,
    output logic [KINDS-1:0] out_req,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ack
);
    localparam int LINKS = DEPTH + 1;

    kind_vec_t        req_w [LINKS];
    logic [WIDTH-1:0] dat_w [LINKS];
    logic             ack_w [LINKS];

    assign req_w[0]     = in_req;
    assign dat_w[0]     = in_data;
    assign in_ack       = ack_w[0];
    assign ack_w[DEPTH] = out_ack;
    assign out_req      = req_w[DEPTH];
    assign out_data     = dat_w[DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        hs3_stage #(.WIDTH(WIDTH)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_up (req_w[g]),
            .d_up   (dat_w[g]),
            .ack_up (ack_w[g]),
            .req_dn (req_w[g+1]),
            .d_dn   (dat_w[g+1]),
            .ack_dn (ack_w[g+1])
        );
    end
endmodule

// File: rtl/hs3_fifo_chk.sv
module hs3_fifo_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       in_req,
    input logic             in_ack,
    input logic [2:0]       out_req,
    input logic [WIDTH-1:0] out_data,
    input logic             out_ack
);
    // R2
    kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_req));

    // R4
    in_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && in_req != 3'b000) |=> in_ack);

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req != 3'b000 && !out_ack) |=> ($stable(out_req) && $stable(out_data)));

    // R6
    broad_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ack |=> $stable(out_data));

    // R7
    no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ack && out_req == 3'b000) |=> (out_req == 3'b000));
endmodule

bind hs3_fifo hs3_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_data (out_data),
    .out_ack  (out_ack)
);

// File: tb/hs3_fifo_tb.sv
module hs3_fifo_tb;
    localparam int DEPTH = 4;
    localparam int W     = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   in_req;
    logic [W-1:0] in_data;
    logic         in_ack;
    logic [2:0]   out_req;
    logic [W-1:0] out_data;
    logic         out_ack;

    always #5 clk = ~clk;

    hs3_fifo #(.DEPTH(DEPTH), .WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
        .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    int accepted = 0;
    bit sink_auto = 0;
    bit drv_busy  = 0;
    int sdly = 0;

    logic [2:0]   exp_k[$];
    logic [W-1:0] exp_d[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Token model: each slot holds a request code (0 = empty) and a word.
    logic [2:0]   m_k [DEPTH];
    logic [W-1:0] m_d [DEPTH];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_k[i] = '0;
                m_d[i] = '0;
            end
        end else begin
            logic [2:0]   nk [DEPTH];
            logic [W-1:0] nd [DEPTH];
            for (int i = 0; i < DEPTH; i++) begin
                logic [2:0] up;
                logic       dn_busy;
                up      = (i == 0) ? in_req : m_k[i-1];
                dn_busy = (i == DEPTH-1) ? out_ack : (m_k[i+1] != 0);
                nk[i] = m_k[i];
                nd[i] = m_d[i];
                if (m_k[i] == 0 && !dn_busy) begin
                    nd[i] = (i == 0) ? in_data : m_d[i-1];
                    nk[i] = up;
                end else if (m_k[i] != 0 && dn_busy && up == 0) begin
                    nk[i] = '0;
                end
            end
            for (int i = 0; i < DEPTH; i++) begin
                m_k[i] = nk[i];
                m_d[i] = nd[i];
            end
        end
    end

    // Cycle compare against the model (R4/R5/R6/R7).
    always @(negedge clk) begin
        if (rst_n) begin
            chk(out_req == m_k[DEPTH-1] && out_data == m_d[DEPTH-1] && in_ack == (m_k[0] != 0),
                "R4/R5/R6/R7 model", {20'd0, in_ack, out_req, out_data},
                {20'd0, (m_k[0] != 0), m_k[DEPTH-1], m_d[DEPTH-1]});
        end
    end

    // R2 scoreboard, called when the sink raises out_ack.
    task automatic take_out();
        if (exp_k.size() == 0) begin
            chk(1'b0, "R2 unexpected flit", {21'd0, out_req, out_data}, 32'd0);
        end else begin
            logic [2:0]   ek;
            logic [W-1:0] ed;
            ek = exp_k.pop_front();
            ed = exp_d.pop_front();
            chk(out_req == ek && out_data == ed, "R2 order", {21'd0, out_req, out_data}, {21'd0, ek, ed});
        end
    endtask

    always @(negedge clk) begin
        if (sink_auto && rst_n) begin
            if (!out_ack && out_req != 0) begin
                if (sdly > 0) sdly--;
                else begin
                    take_out();
                    out_ack = 1'b1;
                    sdly = $urandom % 4;
                end
            end else if (out_ack && out_req == 0) begin
                if (sdly > 0) sdly--;
                else begin
                    out_ack = 1'b0;
                    sdly = $urandom % 3;
                end
            end
        end
    end

    task automatic send_flit(input int kind, input logic [W-1:0] d);
        in_req  = 3'b001 << kind;
        in_data = d;
        while (!in_ack) @(negedge clk);
        exp_k.push_back(3'b001 << kind);
        exp_d.push_back(d);
        accepted++;
        in_req = 3'b000;
        while (in_ack) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "watchdog", cycles, 100000);
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; in_req = '0; in_data = '0; out_ack = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        chk(out_req == 0, "R1 out_req", out_req, 0);
        chk(in_ack == 0, "R1 in_ack", in_ack, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R4: single header, sink idle
        in_req = 3'b001; in_data = 8'hA5;
        exp_k.push_back(3'b001); exp_d.push_back(8'hA5);
        for (int n = 1; n <= DEPTH; n++) begin
            @(negedge clk);
            if (n == 1) chk(in_ack == 1, "R4 ack rise", in_ack, 1);
            if (n == DEPTH - 1) chk(out_req == 0, "R3 not early", out_req, 0);
            if (n == DEPTH) begin
                chk(out_req == 3'b001 && out_data == 8'hA5, "R3 arrival",
                    {21'd0, out_req, out_data}, {21'd0, 3'b001, 8'hA5});
                chk(in_ack == 1, "R4 ack hold", in_ack, 1);
            end
        end
        in_req = 3'b000;
        repeat (5) @(negedge clk);
        // R5
        chk(out_req == 3'b001 && out_data == 8'hA5, "R5 hold", {21'd0, out_req, out_data}, {21'd0, 3'b001, 8'hA5});
        chk(in_ack == 0, "R4 ack fall", in_ack, 0);

        // R6 / R7: keep ack high while the next flit waits
        take_out();
        out_ack = 1'b1;
        fork send_flit(1, 8'h3C); join_none
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            chk(out_req == 0, "R7 no refill", out_req, 0);
            chk(out_data == 8'hA5, "R6 data kept", out_data, 8'hA5);
        end
        out_ack = 1'b0;
        @(negedge clk);
        chk(out_req == 3'b010 && out_data == 8'h3C, "R7 refill", {21'd0, out_req, out_data}, {21'd0, 3'b010, 8'h3C});
        take_out();
        out_ack = 1'b1;
        while (out_req != 0) @(negedge clk);
        out_ack = 1'b0;
        repeat (4) @(negedge clk);

        // R8: capacity under stall
        accepted = 0;
        drv_busy = 1;
        fork
            begin
                for (int i = 0; i < DEPTH + 1; i++) send_flit(1, 8'h10 + i[7:0]);
                drv_busy = 0;
            end
        join_none
        repeat (4 * DEPTH + 10) @(negedge clk);
        chk(accepted == (DEPTH + 1) / 2, "R8 capacity", accepted, (DEPTH + 1) / 2);
        sink_auto = 1;
        while (drv_busy || exp_k.size() != 0) @(negedge clk);

        // R2: packet stream with mixed gaps
        for (int p = 0; p < 8; p++) begin
            send_flit(0, 8'h80 + p[7:0]);
            for (int k = 0; k < p % 4; k++) send_flit(1, {p[3:0], k[3:0]});
            send_flit(2, 8'hE0 + p[7:0]);
            repeat ($urandom % 3) @(negedge clk);
        end
        while (exp_k.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(out_req == 0 && in_ack == 0, "R2 drained", {28'd0, in_ack, out_req}, 0);
        summary();
    end
endmodule